// File: doc/BRIEF.md
# Three-Register Accumulator Processor Core

This block is an 8-bit processor core built around an accumulator (AX) and two auxiliary registers (BX, CX). Every clock cycle it fetches a one-byte opcode from a program ROM at the program counter and executes it. Moves, arithmetic, logic, stack and I/O instructions all finish in a single cycle. Two instructions, a data-RAM load and a conditional jump, carry an operand byte. The ROM port returns that byte alongside the opcode, so these two also finish in one cycle.

The ROM and RAM read ports are combinational: the core presents an address and expects data in the same cycle. A 16-entry internal stack holds values pushed from any of the three registers. The core reads an 8-bit input port directly and writes to a registered 8-bit output port. Each write raises a one-cycle strobe.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted, and immediately after it, the program counter is 0, AX/BX/CX, the overflow flag and the stack pointer are 0, `out_data` is 0 and `out_stb` is low.
- R2: Opcode 0x00 sets AX to 0, 0x31 loads AX from `in_data`, and 0x32 copies AX to `out_data` with `out_stb` high for exactly one cycle per executed 0x32.
- R3: Register moves: 0x01 AX=BX, 0x02 AX=CX, 0x05 BX=AX, 0x06 CX=AX.
- R4: 0x0D AX=AX+BX, 0x0E AX=AX+CX, 0x11 AX=AX-BX, 0x12 AX=AX-CX, all modulo 256.
- R5: 0x0C increments AX and 0x10 decrements AX, modulo 256.
- R6: 0x19 AX=AX|BX, 0x1E AX=AX|CX, 0x14 AX=~AX.
- R7: The overflow flag takes the two's-complement signed overflow of ADD, SUB, INC and DEC. Every other opcode leaves it unchanged.
- R8: 0x4A is followed by a target byte. When the overflow flag is clear it loads the program counter with that target. Otherwise the program counter advances by 2.
- R9: 0x04 is followed by an address byte. It drives that byte on `ram_addr`, loads AX from `ram_rdata` in the same cycle and advances the program counter by 2.
- R10: 0x80/0x81/0x82 push AX/BX/CX and 0x90/0x91/0x92 pop into AX/BX/CX. The two low opcode bits select the register, and the order is last-in first-out.
- R11: The stack holds 16 entries with a pointer that wraps. Push writes and then increments; pop decrements and then reads. A 17th push overwrites the first entry.
- R12: Any other opcode (including 0x83, 0x93, 0xFF) is a one-byte no-operation that changes no register or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rom_addr | output | 8 | Program counter, ROM fetch address |
| rom_op | input | 8 | ROM byte at `rom_addr` (opcode) |
| rom_arg | input | 8 | ROM byte at `rom_addr`+1 (operand) |
| ram_addr | output | 8 | Data RAM read address |
| ram_rdata | input | 8 | Data RAM read data |
| in_data | input | 8 | Input port |
| out_data | output | 8 | Registered output port |
| out_stb | output | 1 | One-cycle pulse per output write |

## Verification
The bench targets the signed-overflow boundaries: 0x7F+1, 0x80-0x7F, 0x01+0x7F, and a decrement from 0 that must clear the flag. A wrong overflow rule sends a conditional jump to the wrong place and so emits the wrong output sequence. Operand bytes placed after loads and jumps decode as live instructions. A core that advanced by only one byte would execute them and emit extra or altered values. The stack is driven past 16 entries, where an unwrapped or off-by-one pointer pops the wrong value. Back-to-back output opcodes expose a strobe that is stretched or merged. Undefined opcodes that resemble pushes and pops would corrupt the stack or AX if decoded loosely.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam logic [7:0] OP_CLR   = 8'h00;
  localparam logic [7:0] OP_IN    = 8'h31;
  localparam logic [7:0] OP_OUT   = 8'h32;
  localparam logic [7:0] OP_A_B   = 8'h01;
  localparam logic [7:0] OP_A_C   = 8'h02;
  localparam logic [7:0] OP_B_A   = 8'h05;
  localparam logic [7:0] OP_C_A   = 8'h06;
  localparam logic [7:0] OP_LDM   = 8'h04;
  localparam logic [7:0] OP_ADDB  = 8'h0D;
  localparam logic [7:0] OP_ADDC  = 8'h0E;
  localparam logic [7:0] OP_SUBB  = 8'h11;
  localparam logic [7:0] OP_SUBC  = 8'h12;
  localparam logic [7:0] OP_INC   = 8'h0C;
  localparam logic [7:0] OP_DEC   = 8'h10;
  localparam logic [7:0] OP_ORB   = 8'h19;
  localparam logic [7:0] OP_ORC   = 8'h1E;
  localparam logic [7:0] OP_NOT   = 8'h14;
  localparam logic [7:0] OP_JNV   = 8'h4A;
  localparam logic [7:0] OP_PUSHA = 8'h80;
  localparam logic [7:0] OP_PUSHB = 8'h81;
  localparam logic [7:0] OP_PUSHC = 8'h82;
  localparam logic [7:0] OP_POPA  = 8'h90;
  localparam logic [7:0] OP_POPB  = 8'h91;
  localparam logic [7:0] OP_POPC  = 8'h92;

  typedef enum logic [2:0] {
    AX_HOLD, AX_ZERO, AX_IN, AX_BX, AX_CX, AX_RAM, AX_ALU, AX_POP
  } ax_src_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR, ALU_NOT} alu_op_e;

  typedef enum logic [1:0] {OPB_BX, OPB_CX, OPB_ONE} opb_sel_e;

  typedef struct packed {
    ax_src_e    ax_src;
    logic       bx_we;
    logic       bx_pop;
    logic       cx_we;
    logic       cx_pop;
    alu_op_e    alu_op;
    opb_sel_e   opb;
    logic       v_we;
    logic       push;
    logic       pop;
    logic [1:0] stk_reg;
    logic       out_en;
    logic       jnv;
    logic       wide;
  } ctl_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [7:0] opcode,
  output ctl_t       ctl
);

  always_comb begin
    ctl = '0;
    unique case (opcode)
      OP_CLR:  ctl.ax_src = AX_ZERO;
      OP_IN:   ctl.ax_src = AX_IN;
      OP_OUT:  ctl.out_en = 1'b1;
      OP_A_B:  ctl.ax_src = AX_BX;
      OP_A_C:  ctl.ax_src = AX_CX;
      OP_B_A:  ctl.bx_we  = 1'b1;
      OP_C_A:  ctl.cx_we  = 1'b1;
      OP_LDM: begin
        ctl.ax_src = AX_RAM;
        ctl.wide   = 1'b1;
      end
      OP_ADDB, OP_ADDC, OP_SUBB, OP_SUBC, OP_INC, OP_DEC: begin
        ctl.ax_src = AX_ALU;
        ctl.v_we   = 1'b1;
        ctl.alu_op = (opcode == OP_SUBB || opcode == OP_SUBC ||
                      opcode == OP_DEC) ? ALU_SUB : ALU_ADD;
        ctl.opb    = (opcode == OP_ADDC || opcode == OP_SUBC) ? OPB_CX :
                     (opcode == OP_INC  || opcode == OP_DEC)  ? OPB_ONE : OPB_BX;
      end
      OP_ORB, OP_ORC: begin
        ctl.ax_src = AX_ALU;
        ctl.alu_op = ALU_OR;
        ctl.opb    = (opcode == OP_ORC) ? OPB_CX : OPB_BX;
      end
      OP_NOT: begin
        ctl.ax_src = AX_ALU;
        ctl.alu_op = ALU_NOT;
      end
      OP_JNV: begin
        ctl.jnv  = 1'b1;
        ctl.wide = 1'b1;
      end
      OP_PUSHA, OP_PUSHB, OP_PUSHC: begin
        ctl.push    = 1'b1;
        ctl.stk_reg = opcode[1:0];
      end
      OP_POPA, OP_POPB, OP_POPC: begin
        ctl.pop     = 1'b1;
        ctl.stk_reg = opcode[1:0];
        if (opcode[1:0] == 2'd0) ctl.ax_src = AX_POP;
        if (opcode[1:0] == 2'd1) begin ctl.bx_we = 1'b1; ctl.bx_pop = 1'b1; end
        if (opcode[1:0] == 2'd2) begin ctl.cx_we = 1'b1; ctl.cx_pop = 1'b1; end
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_op_e       op,
  output logic [DW-1:0] y,
  output logic          v
);

  localparam int MSB = DW - 1;

  always_comb begin
    y = '0;
    v = 1'b0;
    unique case (op)
      ALU_ADD: begin
        y = a + b;
        v = (a[MSB] == b[MSB]) && (y[MSB] != a[MSB]);
      end
      ALU_SUB: begin
        y = a - b;
        v = (a[MSB] != b[MSB]) && (y[MSB] != a[MSB]);
      end
      ALU_OR:  y = a | b;
      ALU_NOT: y = ~a;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/acc_stack.sv
module acc_stack #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic                     pop,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata,
  output logic [$clog2(DEPTH)-1:0] sp
);

  localparam int SPW = $clog2(DEPTH);

  logic [DW-1:0]  mem [DEPTH];
  logic [SPW-1:0] sp_q, sp_d, top_idx;
  logic           sp_en;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (push && (sp_q == SPW'(i))) mem[i] <= wdata;
    end
  end

  assign top_idx = sp_q - SPW'(1);
  assign rdata   = mem[top_idx];

  always_comb begin
    sp_en = push | pop;
    sp_d  = push ? sp_q + SPW'(1) : top_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '0;
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp = sp_q;

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DW        = 8,
  parameter int STK_DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] rom_addr,
  input  logic [7:0]    rom_op,
  input  logic [DW-1:0] rom_arg,
  output logic [DW-1:0] ram_addr,
  input  logic [DW-1:0] ram_rdata,
  input  logic [DW-1:0] in_data,
  output logic [DW-1:0] out_data,
  output logic          out_stb
);

  localparam int SPW = $clog2(STK_DEPTH);

  logic rs_meta, rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_i_n <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_i_n <= rs_meta;
    end
  end

  ctl_t           ctl;
  logic [DW-1:0]  ax_q, bx_q, cx_q, pc_q, out_q;
  logic [DW-1:0]  ax_d, bx_d, cx_d, pc_d;
  logic           v_q, v_d, stb_q;
  logic           ax_en;
  logic [DW-1:0]  opb, alu_y, stk_wdata, stk_top;
  logic           alu_v;
  logic [SPW-1:0] sp_q;

  acc_decode u_dec (
    .opcode (rom_op),
    .ctl    (ctl)
  );

  always_comb begin
    unique case (ctl.opb)
      OPB_CX:  opb = cx_q;
      OPB_ONE: opb = DW'(1);
      default: opb = bx_q;
    endcase
  end

  acc_alu #(.DW(DW)) u_alu (
    .a  (ax_q),
    .b  (opb),
    .op (ctl.alu_op),
    .y  (alu_y),
    .v  (alu_v)
  );

  always_comb begin
    unique case (ctl.stk_reg)
      2'd1:    stk_wdata = bx_q;
      2'd2:    stk_wdata = cx_q;
      default: stk_wdata = ax_q;
    endcase
  end

  acc_stack #(.DW(DW), .DEPTH(STK_DEPTH)) u_stk (
    .clk   (clk),
    .rst_n (rst_i_n),
    .push  (ctl.push),
    .pop   (ctl.pop),
    .wdata (stk_wdata),
    .rdata (stk_top),
    .sp    (sp_q)
  );

  always_comb begin
    ax_en = (ctl.ax_src != AX_HOLD);
    unique case (ctl.ax_src)
      AX_ZERO: ax_d = '0;
      AX_IN:   ax_d = in_data;
      AX_BX:   ax_d = bx_q;
      AX_CX:   ax_d = cx_q;
      AX_RAM:  ax_d = ram_rdata;
      AX_ALU:  ax_d = alu_y;
      AX_POP:  ax_d = stk_top;
      default: ax_d = ax_q;
    endcase
    bx_d = ctl.bx_pop ? stk_top : ax_q;
    cx_d = ctl.cx_pop ? stk_top : ax_q;
    v_d  = alu_v;
    if (ctl.jnv && !v_q) pc_d = rom_arg;
    else                 pc_d = pc_q + (ctl.wide ? DW'(2) : DW'(1));
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ax_q  <= '0;
      bx_q  <= '0;
      cx_q  <= '0;
      pc_q  <= '0;
      v_q   <= 1'b0;
      out_q <= '0;
      stb_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      stb_q <= ctl.out_en;
      if (ax_en)      ax_q  <= ax_d;
      if (ctl.bx_we)  bx_q  <= bx_d;
      if (ctl.cx_we)  cx_q  <= cx_d;
      if (ctl.v_we)   v_q   <= v_d;
      if (ctl.out_en) out_q <= ax_q;
    end
  end

  assign rom_addr = pc_q;
  assign ram_addr = rom_arg;
  assign out_data = out_q;
  assign out_stb  = stb_q;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DW  = 8,
  parameter int SPW = 4
) (
  input logic           clk,
  input logic           rst_i_n,
  input logic [7:0]     rom_op,
  input logic [DW-1:0]  rom_arg,
  input logic [DW-1:0]  rom_addr,
  input logic           out_stb,
  input logic           v_q,
  input logic [SPW-1:0] sp_q
);

  a_r2_strobe_src: assert property (@(posedge clk) disable iff (!rst_i_n)
    out_stb |-> ($past(rom_op) == 8'h32));

  a_r8_jump_taken: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rom_op == 8'h4A && !v_q) |=> (rom_addr == $past(rom_arg)));

  a_r8_jump_skip: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rom_op == 8'h4A && v_q) |=> (rom_addr == DW'($past(rom_addr) + DW'(2))));

  a_r12_undef_step: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rom_op == 8'hFF) |=> (rom_addr == DW'($past(rom_addr) + DW'(1))));

  a_r11_push_ptr: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rom_op inside {8'h80, 8'h81, 8'h82}) |=> (sp_q == SPW'($past(sp_q) + SPW'(1))));

  a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rom_op inside {8'h01, 8'h02, 8'h05, 8'h06, 8'h14, 8'h19, 8'h1E}) |=> $stable(v_q));

endmodule

bind acc_core acc_core_chk #(.DW(DW), .SPW(SPW)) u_chk (
  .clk      (clk),
  .rst_i_n  (rst_i_n),
  .rom_op   (rom_op),
  .rom_arg  (rom_arg),
  .rom_addr (rom_addr),
  .out_stb  (out_stb),
  .v_q      (v_q),
  .sp_q     (sp_q)
);

// File: tb/test_acc_core.sv
`timescale 1ns/1ps
module test_acc_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rom_addr, rom_op, rom_arg, ram_addr, ram_rdata;
  logic [7:0] in_data = 8'h00;
  logic [7:0] out_data;
  logic       out_stb;

  logic [7:0] rom [256];
  int         wp;
  logic [7:0] olog [64];
  int         ocnt;
  int         n_chk = 0;
  int         n_bad = 0;
  int         cyc = 0;

  always #2.5 clk = ~clk;

  assign rom_op    = rom[rom_addr];
  assign rom_arg   = rom[8'(rom_addr + 8'd1)];
  assign ram_rdata = ram_addr ^ 8'h5A;

  acc_core i_acc_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .rom_addr  (rom_addr),
    .rom_op    (rom_op),
    .rom_arg   (rom_arg),
    .ram_addr  (ram_addr),
    .ram_rdata (ram_rdata),
    .in_data   (in_data),
    .out_data  (out_data),
    .out_stb   (out_stb)
  );

  always @(negedge clk) begin
    if (rst_n && out_stb) begin
      if (ocnt < 64) olog[ocnt] = out_data;
      ocnt = ocnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_cnt(input string req, input int exp);
    n_chk = n_chk + 1;
    if (ocnt != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0d outputs expected %0d", req, ocnt, exp);
    end
  endtask

  task automatic chk_out(input string req, input int idx, input logic [7:0] exp);
    if (idx >= ocnt) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL %s: actual missing output %0d expected %h", req, idx, exp);
    end else chk(req, olog[idx], exp);
  endtask

  task automatic clr_prog();
    for (int i = 0; i < 256; i++) rom[i] = 8'hFF;
    wp = 0;
  endtask

  task automatic emit(input logic [7:0] b);
    rom[wp] = b;
    wp = wp + 1;
  endtask

  task automatic run(input int n);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    ocnt = 0;
    repeat (n) @(negedge clk);
  endtask

  // R1: reset state
  task automatic t_reset();
    clr_prog();
    in_data = 8'h5A;
    emit(8'h31); emit(8'h05); emit(8'h06); emit(8'h32);
    run(20);
    chk("R1 pre-reset out", out_data, 8'h5A);
    rst_n = 1'b0;
    #1;
    chk("R1 pc in reset", rom_addr, 8'h00);
    chk("R1 out in reset", out_data, 8'h00);
    chk("R1 stb in reset", {7'd0, out_stb}, 8'h00);
    clr_prog();
    emit(8'h32); emit(8'h01); emit(8'h32); emit(8'h02); emit(8'h32);
    run(20);
    chk_cnt("R1 out count", 3);
    chk_out("R1 AX cleared", 0, 8'h00);
    chk_out("R1 BX cleared", 1, 8'h00);
    chk_out("R1 CX cleared", 2, 8'h00);
  endtask

  // R2, R3: input, clear, output, moves
  task automatic t_moves();
    clr_prog();
    in_data = 8'h3C;
    emit(8'h31); emit(8'h05); emit(8'h00); emit(8'h32);
    emit(8'h01); emit(8'h32); emit(8'h06); emit(8'h00);
    emit(8'h32); emit(8'h02); emit(8'h32);
    run(30);
    chk_cnt("R2 one strobe per out", 4);
    chk_out("R2 clear", 0, 8'h00);
    chk_out("R3 AX=BX", 1, 8'h3C);
    chk_out("R2 clear again", 2, 8'h00);
    chk_out("R3 AX=CX", 3, 8'h3C);
  endtask

  // R4, R5: arithmetic wrap
  task automatic t_arith();
    clr_prog();
    in_data = 8'hF0;
    emit(8'h31); emit(8'h05); emit(8'h00); emit(8'h0C); emit(8'h0C); emit(8'h0C);
    emit(8'h06); emit(8'h01); emit(8'h0E); emit(8'h32);
    emit(8'h0D); emit(8'h32); emit(8'h12); emit(8'h32);
    emit(8'h11); emit(8'h32); emit(8'h10); emit(8'h32);
    emit(8'h00); emit(8'h10); emit(8'h32); emit(8'h0C); emit(8'h32);
    run(40);
    chk_out("R4 add CX", 0, 8'hF3);
    chk_out("R4 add BX wrap", 1, 8'hE3);
    chk_out("R4 sub CX", 2, 8'hE0);
    chk_out("R4 sub BX wrap", 3, 8'hF0);
    chk_out("R5 dec", 4, 8'hEF);
    chk_out("R5 dec wrap", 5, 8'hFF);
    chk_out("R5 inc wrap", 6, 8'h00);
  endtask

  // R6: logic and back-to-back strobes
  task automatic t_logic();
    clr_prog();
    in_data = 8'hA5;
    emit(8'h31); emit(8'h05); emit(8'h00); emit(8'h0C); emit(8'h0C); emit(8'h06);
    emit(8'h00); emit(8'h19); emit(8'h32); emit(8'h1E); emit(8'h32);
    emit(8'h14); emit(8'h32); emit(8'h32);
    run(30);
    chk_cnt("R2 back-to-back strobes", 4);
    chk_out("R6 or BX", 0, 8'hA5);
    chk_out("R6 or CX", 1, 8'hA7);
    chk_out("R6 not", 2, 8'h58);
    chk_out("R6 not repeat", 3, 8'h58);
  endtask

  // R7, R8: overflow flag and conditional jump
  task automatic t_flag();
    clr_prog();
    in_data = 8'h7F;
    emit(8'h31); emit(8'h0C);                 // AX=80 V=1
    emit(8'h4A); emit(8'h40); emit(8'h32);    // not taken, out 80
    emit(8'h00); emit(8'h05);                 // V stays 1
    emit(8'h4A); emit(8'h40); emit(8'h32);    // not taken, out 00
    emit(8'h10);                              // AX=FF V=0
    emit(8'h4A); emit(8'h30);                 // taken
    emit(8'h0C); emit(8'h32);                 // skipped
    wp = 8'h30;
    emit(8'h32);                              // out FF
    emit(8'h31); emit(8'h05); emit(8'h0C);    // BX=7F AX=80 V=1
    emit(8'h11);                              // 80-7F=01 V=1
    emit(8'h4A); emit(8'h60); emit(8'h32);    // out 01
    emit(8'h0D);                              // 01+7F=80 V=1
    emit(8'h4A); emit(8'h60); emit(8'h32);    // out 80
    emit(8'h0D);                              // 80+7F=FF V=0
    emit(8'h4A); emit(8'h60); emit(8'h32);    // taken, 32 skipped
    wp = 8'h60;
    emit(8'h32);
    run(60);
    chk_cnt("R8 output count", 6);
    chk_out("R8 inc overflow no jump", 0, 8'h80);
    chk_out("R7 flag held by clear/move", 1, 8'h00);
    chk_out("R8 jump taken after dec", 2, 8'hFF);
    chk_out("R7 sub overflow", 3, 8'h01);
    chk_out("R7 add overflow", 4, 8'h80);
    chk_out("R8 add no overflow jump", 5, 8'hFF);
  endtask

  // R9: RAM load with operand skip
  task automatic t_ram();
    clr_prog();
    emit(8'h04); emit(8'h10); emit(8'h32);
    emit(8'h04); emit(8'hC3); emit(8'h32);
    run(20);
    chk_cnt("R9 operand skipped", 2);
    chk_out("R9 load 10", 0, 8'h4A);
    chk_out("R9 load C3", 1, 8'h99);
  endtask

  // R10: LIFO order and register select
  task automatic t_stack();
    clr_prog();
    in_data = 8'h11;
    emit(8'h31); emit(8'h05); emit(8'h0C); emit(8'h06); emit(8'h0C);
    emit(8'h80); emit(8'h81); emit(8'h82);
    emit(8'h00); emit(8'h90); emit(8'h32);
    emit(8'h91); emit(8'h92);
    emit(8'h01); emit(8'h32); emit(8'h02); emit(8'h32);
    run(30);
    chk_out("R10 pop AX", 0, 8'h12);
    chk_out("R10 pop BX", 1, 8'h11);
    chk_out("R10 pop CX", 2, 8'h13);
  endtask

  // R11: pointer wrap
  task automatic t_wrap();
    clr_prog();
    emit(8'h00);
    for (int i = 0; i < 17; i++) begin
      emit(8'h0C); emit(8'h80);
    end
    emit(8'h90); emit(8'h32); emit(8'h90); emit(8'h32);
    run(60);
    chk_out("R11 17th push overwrote entry 0", 0, 8'h11);
    chk_out("R11 pop wraps to entry 15", 1, 8'h10);
  endtask

  // R12: undefined opcodes
  task automatic t_undef();
    clr_prog();
    in_data = 8'h66;
    emit(8'h31); emit(8'h80);
    emit(8'hFF); emit(8'h83); emit(8'h93); emit(8'h4B); emit(8'h33);
    emit(8'h32); emit(8'h0C); emit(8'h32);
    emit(8'h00); emit(8'h90); emit(8'h32);
    run(30);
    chk_cnt("R12 output count", 3);
    chk_out("R12 AX untouched", 0, 8'h66);
    chk_out("R12 one-byte step", 1, 8'h67);
    chk_out("R12 stack untouched", 2, 8'h66);
  endtask

  initial begin
    ocnt = 0;
    clr_prog();
    t_reset();
    t_moves();
    t_arith();
    t_logic();
    t_flag();
    t_ram();
    t_stack();
    t_wrap();
    t_undef();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule